// File: doc/BRIEF.md
# Condition-Branching Operator Sequencer

The block walks a small stored program of operators, one slot at a time. Every slot holds one of three operator kinds. An action operator asks an outside engine to run one elementary processing step, identified by an index, and waits until that engine acknowledges it. A test operator looks at one bit of an external condition vector. It either falls through to the neighbouring slot or jumps to a slot that the operator names. A stop operator ends the run. The next slot is therefore a logic function of the present slot and the condition bits. A constant-true successor is a plain fall-through, and an impossible successor is never taken.

The program is loaded through a write port. A start pulse launches the run at slot 0. The run finishes by raising a done flag, or by raising an error flag when control would leave the program range. The processing steps themselves are outside the block. Only their request and acknowledge handshake is seen here.

Top module: `opseq_top`

## Requirements
- R1: When the sequencer is idle, done or in error, a start pulse sampled high makes busy high on the next cycle with execution at slot 0, and clears done and error.
- R2: A write with prog_we high stores prog_data in slot prog_addr. The entry layout is kind in bits [9:8] (00 action, 01 test, 10 stop, 11 reserved), selector in bits [7:4] and branch target in bits [3:0].
- R3: An action operator raises act_req one cycle after it is reached, with act_index equal to the selector. Both hold steady until act_ack is sampled high. The cycle after that, act_req is low and control is at the following slot.
- R4: A test operator takes exactly one cycle. When cond[selector mod COND_W] is 1, control moves to the following slot.
- R5: When that condition bit is 0, control moves to the branch target slot.
- R6: A stop operator ends the run one cycle after it is reached. Busy falls and done rises, and done stays high until the next start.
- R7: A taken branch target at or above DEPTH, a fall-through past the last slot, or a reserved kind makes busy fall and error rise. Error stays high until the next start.
- R8: A start pulse while busy is ignored. The action sequence and the run length are unchanged.
- R9: After reset, busy, done, error and act_req are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program write enable |
| prog_addr | input | 4 | Program slot to write |
| prog_data | input | 10 | Operator entry to write |
| start | input | 1 | Launch request |
| cond | input | COND_W (4) | External condition bits |
| act_ack | input | 1 | Completion of the requested step |
| act_req | output | 1 | Step request, held until acknowledged |
| act_index | output | 4 | Index of the requested step |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run reached a stop operator |
| error | output | 1 | Last run left the program range or hit a reserved kind |

## Verification
Two programs are tried against every combination of condition bits.

The first has a single test per selector. Its trace shows whether the fall-through and the jump are told apart for each bit position. The second chains three tests into four exits. It separates a wrong selector from a wrong target, and a wrong target from a wrong fall-through.

Action chains run with delayed acknowledges and with a start pulse arriving mid-run. The run length, counted in busy cycles, exposes any extra or missing cycle per operator. Out-of-range targets, a fall-off past the last slot and a reserved kind each have to end in error rather than done.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

    localparam int SLOT_AW = 4;
    localparam int OPSEL_W = 4;

    typedef enum logic [1:0] {
        OPK_ACT  = 2'b00,
        OPK_TEST = 2'b01,
        OPK_STOP = 2'b10,
        OPK_RSV  = 2'b11
    } op_kind_e;

    typedef struct packed {
        op_kind_e             kind;
        logic [OPSEL_W-1:0]   sel;
        logic [SLOT_AW-1:0]   tgt;
    } op_entry_t;

    localparam int ENTRY_W = $bits(op_entry_t);

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_EXEC = 3'd1,
        ST_WAIT = 3'd2,
        ST_DONE = 3'd3,
        ST_ERR  = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e           st;
        logic [SLOT_AW-1:0]   pc;
        logic [OPSEL_W-1:0]   idx;
    } seq_ctx_t;

    function automatic logic slot_ok(input logic [SLOT_AW:0] a, input int depth);
        return int'(a) < depth;
    endfunction

endpackage

// File: rtl/opseq_store.sv
module opseq_store
    import opseq_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [SLOT_AW-1:0]   wr_addr,
    input  op_entry_t            wr_entry,
    input  logic [SLOT_AW-1:0]   rd_addr,
    output op_entry_t            rd_entry
);
    op_entry_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            slots[wr_addr] <= wr_entry;
        end
    end

    always_comb begin
        if (int'(rd_addr) < DEPTH) begin
            rd_entry = slots[rd_addr];
        end else begin
            rd_entry = '{kind: OPK_RSV, sel: '0, tgt: '0};
        end
    end
endmodule

// File: rtl/opseq_pick.sv
module opseq_pick
    import opseq_pkg::*;
#(
    parameter int COND_W = 4
) (
    input  logic [COND_W-1:0]  cond,
    input  logic [OPSEL_W-1:0] sel,
    output logic               bit_o
);
    generate
        if (COND_W == 1) begin : g_single
            assign bit_o = cond[0];
        end else begin : g_mux
            localparam int CSW = $clog2(COND_W);
            assign bit_o = cond[sel[CSW-1:0]];
        end
    endgenerate
endmodule

// File: rtl/opseq_step.sv
module opseq_step
    import opseq_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  seq_ctx_t   cur,
    input  op_entry_t  entry,
    input  logic       cond_bit,
    input  logic       start,
    input  logic       ack,
    output seq_ctx_t   nxt
);
    logic [SLOT_AW:0] pc_inc;
    logic [SLOT_AW:0] dest;

    assign pc_inc = {1'b0, cur.pc} + 1'b1;
    assign dest   = cond_bit ? pc_inc : {1'b0, entry.tgt};

    always_comb begin
        nxt = cur;
        unique case (cur.st)
            ST_IDLE, ST_DONE, ST_ERR: begin
                if (start) begin
                    nxt.st = ST_EXEC;
                    nxt.pc = '0;
                end
            end
            ST_EXEC: begin
                unique case (entry.kind)
                    OPK_ACT: begin
                        nxt.st  = ST_WAIT;
                        nxt.idx = entry.sel;
                    end
                    OPK_TEST: begin
                        if (slot_ok(dest, DEPTH)) begin
                            nxt.pc = dest[SLOT_AW-1:0];
                        end else begin
                            nxt.st = ST_ERR;
                        end
                    end
                    OPK_STOP: nxt.st = ST_DONE;
                    default:  nxt.st = ST_ERR;
                endcase
            end
            ST_WAIT: begin
                if (ack) begin
                    if (slot_ok(pc_inc, DEPTH)) begin
                        nxt.st = ST_EXEC;
                        nxt.pc = pc_inc[SLOT_AW-1:0];
                    end else begin
                        nxt.st = ST_ERR;
                    end
                end
            end
            default: nxt.st = ST_ERR;
        endcase
    end
endmodule

// File: rtl/opseq_top.sv
module opseq_top
    import opseq_pkg::*;
#(
    parameter int DEPTH  = 12,
    parameter int COND_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prog_we,
    input  logic [SLOT_AW-1:0]   prog_addr,
    input  logic [ENTRY_W-1:0]   prog_data,
    input  logic                 start,
    input  logic [COND_W-1:0]    cond,
    input  logic                 act_ack,
    output logic                 act_req,
    output logic [OPSEL_W-1:0]   act_index,
    output logic                 busy,
    output logic                 done,
    output logic                 error
);
    seq_ctx_t  ctx_q;
    seq_ctx_t  ctx_d;
    op_entry_t cur_entry;
    logic      cond_bit;

    opseq_store #(.DEPTH(DEPTH)) store_i (
        .clk      (clk),
        .wr_en    (prog_we),
        .wr_addr  (prog_addr),
        .wr_entry (op_entry_t'(prog_data)),
        .rd_addr  (ctx_q.pc),
        .rd_entry (cur_entry)
    );

    opseq_pick #(.COND_W(COND_W)) pick_i (
        .cond  (cond),
        .sel   (cur_entry.sel),
        .bit_o (cond_bit)
    );

    opseq_step #(.DEPTH(DEPTH)) step_i (
        .cur      (ctx_q),
        .entry    (cur_entry),
        .cond_bit (cond_bit),
        .start    (start),
        .ack      (act_ack),
        .nxt      (ctx_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '{st: ST_IDLE, pc: '0, idx: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign act_req   = (ctx_q.st == ST_WAIT);
    assign act_index = ctx_q.idx;
    assign busy      = (ctx_q.st == ST_EXEC) || (ctx_q.st == ST_WAIT);
    assign done      = (ctx_q.st == ST_DONE);
    assign error     = (ctx_q.st == ST_ERR);
endmodule

// File: rtl/opseq_chk.sv
module opseq_chk
    import opseq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               act_ack,
    input logic               act_req,
    input logic [OPSEL_W-1:0] act_index,
    input logic               busy,
    input logic               done,
    input logic               error
);
    assert_launch_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !done && !error));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (act_req && !act_ack) |=> (act_req && $stable(act_index)));

    assert_req_release_R3: assert property (@(posedge clk) disable iff (rst)
        (act_req && act_ack) |=> !act_req);

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    assert_err_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (error && !start) |=> error);

    assert_rise_needs_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({busy, done, error}));
endmodule

bind opseq_top opseq_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .act_ack   (act_ack),
    .act_req   (act_req),
    .act_index (act_index),
    .busy      (busy),
    .done      (done),
    .error     (error)
);

// File: tb/opseq_top_tb_top.sv
module opseq_top_tb_top;
    localparam int DEPTH  = 12;
    localparam int COND_W = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_we = 1'b0;
    logic [3:0] prog_addr = '0;
    logic [9:0] prog_data = '0;
    logic       start = 1'b0;
    logic [3:0] cond = '0;
    logic       act_ack = 1'b0;
    logic       act_req;
    logic [3:0] act_index;
    logic       busy, done, error;

    int n_chk = 0;
    int n_bad = 0;
    int tr [8];
    int tr_n;
    int busy_n;

    always #5 clk = ~clk;

    opseq_top #(.DEPTH(DEPTH), .COND_W(COND_W)) dut_i (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .start(start), .cond(cond), .act_ack(act_ack),
        .act_req(act_req), .act_index(act_index), .busy(busy), .done(done),
        .error(error)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // kind: 0 action, 1 test, 2 stop, 3 reserved
    task automatic put(input int slot, input int kind, input int sel, input int tgt);
        @(negedge clk);
        prog_we   = 1'b1;
        prog_addr = 4'(slot);
        prog_data = {2'(kind), 4'(sel), 4'(tgt)};
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic fill_stop();
        for (int i = 0; i < DEPTH; i++) put(i, 2, 0, 0);
    endtask

    task automatic run(input int delay, input bit poke);
        int wait_n;
        bit poked;
        tr_n = 0; busy_n = 0; wait_n = 0; poked = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (!busy) break;
            busy_n++;
            act_ack = 1'b0;
            start   = 1'b0;
            if (act_req) begin
                if (poke && !poked) begin
                    start = 1'b1;
                    poked = 1'b1;
                end
                if (wait_n == delay) begin
                    if (tr_n < 8) tr[tr_n] = int'(act_index);
                    tr_n++;
                    act_ack = 1'b1;
                    wait_n  = 0;
                end else begin
                    wait_n++;
                end
            end
            @(negedge clk);
        end
        act_ack = 1'b0;
        start   = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 busy", int'(busy), 0);
        chk("R9 done", int'(done), 0);
        chk("R9 error", int'(error), 0);
        chk("R9 act_req", int'(act_req), 0);

        // R4/R5 single test sweep over selector and all condition values
        fill_stop();
        put(1, 0, 1, 0);
        put(5, 0, 5, 0);
        for (int s = 0; s < 4; s++) begin
            put(0, 1, s + 4 * (s % 2), 5);   // selector above COND_W wraps modulo
            for (int c = 0; c < 16; c++) begin
                cond = 4'(c);
                run(0, 1'b0);
                chk(((c >> s) & 1) != 0 ? "R4 fall-through idx" : "R5 jump idx",
                    tr[0], ((c >> s) & 1) != 0 ? 1 : 5);
                chk("R4 one-cycle test run length", busy_n, 4);
                chk("R6 done after stop", int'(done), 1);
            end
        end

        // R4/R5 three-test chain, four exits
        fill_stop();
        put(0, 1, 0, 4);
        put(1, 1, 1, 7);
        put(2, 0, 2, 0);
        put(4, 1, 2, 9);
        put(5, 0, 5, 0);
        put(7, 0, 7, 0);
        put(9, 0, 9, 0);
        for (int c = 0; c < 16; c++) begin
            int e;
            cond = 4'(c);
            if ((c & 1) != 0) e = ((c & 2) != 0) ? 2 : 7;
            else              e = ((c & 4) != 0) ? 5 : 9;
            run(0, 1'b0);
            chk("R5 chain exit idx", tr[0], e);
            chk("R4 chain run length", busy_n, 5);
        end

        // R3 action chain with delayed acknowledge, R2 overwrite of a slot
        fill_stop();
        put(0, 0, 3, 0);
        put(1, 0, 7, 0);
        put(2, 0, 9, 0);
        for (int d = 0; d < 4; d++) begin
            run(d, 1'b0);
            chk("R3 action count", tr_n, 3);
            chk("R3 first idx", tr[0], 3);
            chk("R3 third idx", tr[2], 9);
            chk("R3 run length", busy_n, 1 + 3 * (2 + d));
        end
        put(1, 0, 12, 0);
        run(0, 1'b0);
        chk("R2 rewritten slot idx", tr[1], 12);

        // R8 start during a run
        run(2, 1'b1);
        chk("R8 action count", tr_n, 3);
        chk("R8 run length", busy_n, 13);
        chk("R8 second idx", tr[1], 12);

        // R6 done holds, R1 restart clears it
        repeat (5) @(negedge clk);
        chk("R6 done held", int'(done), 1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R1 busy after start", int'(busy), 1);
        chk("R1 done cleared", int'(done), 0);
        run(0, 1'b0);

        // R7 out-of-range target, taken and not taken
        fill_stop();
        put(0, 1, 0, 13);
        put(1, 0, 1, 0);
        cond = 4'b0000;
        run(0, 1'b0);
        chk("R7 error on bad target", int'(error), 1);
        chk("R7 no action", tr_n, 0);
        chk("R7 run length", busy_n, 1);
        repeat (4) @(negedge clk);
        chk("R7 error held", int'(error), 1);
        cond = 4'b0001;
        run(0, 1'b0);
        chk("R1 error cleared, fall-through ok", int'(done), 1);
        chk("R4 idx with bad unused target", tr[0], 1);

        // R7 fall past last slot
        put(0, 1, 0, 11);
        put(11, 0, 4, 0);
        cond = 4'b0000;
        run(0, 1'b0);
        chk("R7 last action idx", tr[0], 4);
        chk("R7 error after fall-off", int'(error), 1);

        // R7 reserved kind
        put(0, 3, 0, 0);
        run(0, 1'b0);
        chk("R7 error on reserved", int'(error), 1);
        chk("R7 reserved done low", int'(done), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule